// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit sits next to a small word-addressed memory shared by several processors and carries out every access to it as one indivisible step. A processor asks for a plain load or store, an atomic swap, a test-and-set, a fetch-and-increment, or a load-linked / store-conditional pair. The unit picks one requester per cycle and performs the whole read and write for it. A registered response then carries the old memory word, or a success flag for a store-conditional, back to that processor.

Each processor owns one reservation register. A load-linked fills it, and a store-conditional depends on it. Any write to the reserved word by another processor cancels the reservation, so a later store-conditional fails and leaves memory untouched. Lock code built on swap or test-and-set reads a returned zero as "acquired" and a non-zero return as "already held".

Top module: `amo_unit`

## Requirements
- R1: After reset every memory word reads 0, no reservation is valid, `rsp_valid` is low, and when all processors request together the first grant goes to processor 0.
- R2: Operation codes on `req_op` are 0 load, 1 store, 2 swap, 3 test-and-set, 4 fetch-and-increment, 5 load-linked, 6 store-conditional, and 7 behaves as a load. A load returns the word and changes nothing. A store writes `req_wdata` and returns the previous word.
- R3: Swap writes `req_wdata` and returns the previous word in the same operation, so a second swap of 1 onto a lock returns 1.
- R4: Test-and-set returns the old word and writes `req_wdata` only when the old word is 0. Otherwise memory is unchanged.
- R5: Fetch-and-increment returns the old word and stores the old word plus one, modulo 2^DW.
- R6: Load-linked returns the word and reserves its address for the requester. A following store-conditional to that address by the same processor writes `req_wdata` and returns 1. A store-conditional response is always 0 or 1.
- R7: A store-conditional returns 0 and leaves memory unchanged if another processor wrote the reserved address after the load-linked. Writes to other addresses do not cancel the reservation.
- R8: A store-conditional with no valid reservation, or with a reservation for a different address, returns 0 and writes nothing. Every store-conditional clears the requester's own reservation.
- R9: At most one processor is granted per cycle, and only one that requests. An idle cycle with a pending request never occurs. Grants rotate round-robin starting after the last granted processor.
- R10: A response appears exactly one cycle after each grant, with `rsp_id` equal to the granted processor. `rsp_valid` is low in cycles that follow no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPROC | Request pending, one bit per processor |
| req_op | input | 3*NPROC | Operation code per processor, processor p at bits [3p+2:3p] |
| req_addr | input | AW*NPROC | Word address per processor |
| req_wdata | input | DW*NPROC | Write value per processor |
| req_grant | output | NPROC | One-hot grant; the granted request executes at this clock edge |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | $clog2(NPROC) | Processor the response belongs to |
| rsp_data | output | DW | Old memory word, or store-conditional success flag |

## Verification
The lock primitives are tried on a free word and then on a held word. Because the second attempt's return value differs, a swap or test-and-set that skipped its write or returned the new value shows up. Fetch-and-increment is run up to the all-ones word to expose a missing wrap. Store-conditional is tried after a clean load-linked, after another processor's write to the same address, after a write to some other address, without any reservation, at a mismatching address, and a second time after a success. Each of these cases separates a different reservation-clearing rule. All processors requesting at once shows the rotation order, and it also shows that each response carries the identity of the processor granted one cycle earlier.

// File: rtl/amo_pkg.sv
package amo_pkg;
   typedef enum logic [2:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_SWAP  = 3'd2,
      OP_TAS   = 3'd3,
      OP_FINC  = 3'd4,
      OP_LL    = 3'd5,
      OP_SC    = 3'd6,
      OP_RSVD  = 3'd7
   } amo_op_e;
endpackage

// File: rtl/amo_rr_arb.sv
module amo_rr_arb #(
   parameter int N  = 4,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] gnt_id,
   output logic          gnt_any
);
   logic [IW-1:0] last_q;

   // search starts one past the last winner
   always_comb begin
      grant   = '0;
      gnt_id  = '0;
      gnt_any = 1'b0;
      for (int k = 1; k <= N; k++) begin
         int idx;
         idx = (int'(last_q) + k) % N;
         if (!gnt_any && req[idx]) begin
            gnt_any    = 1'b1;
            grant[idx] = 1'b1;
            gnt_id     = IW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       last_q <= IW'(N - 1);
      else if (gnt_any) last_q <= gnt_id;
   end
endmodule

// File: rtl/amo_alu.sv
module amo_alu import amo_pkg::*; #(
   parameter int DW          = 16,
   parameter bit TAS_SET_ONE = 1'b0
) (
   input  amo_op_e       op,
   input  logic [DW-1:0] old_val,
   input  logic [DW-1:0] wdata,
   input  logic          sc_ok,
   output logic          do_wr,
   output logic [DW-1:0] new_val,
   output logic [DW-1:0] rsp_val
);
   logic [DW-1:0] tas_val;

   generate
      if (TAS_SET_ONE) begin : g_tas_one
         assign tas_val = DW'(1);
      end else begin : g_tas_data
         assign tas_val = wdata;
      end
   endgenerate

   always_comb begin
      do_wr   = 1'b0;
      new_val = wdata;
      rsp_val = old_val;
      unique case (op)
         OP_STORE, OP_SWAP: do_wr = 1'b1;
         OP_TAS: begin
            do_wr   = (old_val == '0);
            new_val = tas_val;
         end
         OP_FINC: begin
            do_wr   = 1'b1;
            new_val = old_val + DW'(1);
         end
         OP_SC: begin
            do_wr   = sc_ok;
            rsp_val = DW'(sc_ok);
         end
         default: do_wr = 1'b0;
      endcase
   end
endmodule

// File: rtl/amo_resv.sv
module amo_resv import amo_pkg::*; #(
   parameter int NPROC = 4,
   parameter int AW    = 4,
   localparam int IW   = $clog2(NPROC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act,
   input  logic [IW-1:0] id,
   input  logic [2:0]    op,
   input  logic [AW-1:0] addr,
   input  logic          wr_done,
   output logic          sc_ok
);
   logic          v_q [NPROC];
   logic [AW-1:0] a_q [NPROC];

   generate
      for (genvar g = 0; g < NPROC; g++) begin : g_entry
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q[g] <= 1'b0;
               a_q[g] <= '0;
            end else if (act) begin
               if (IW'(g) == id) begin
                  if (op == OP_LL) begin
                     v_q[g] <= 1'b1;
                     a_q[g] <= addr;
                  end else if (op == OP_SC) begin
                     v_q[g] <= 1'b0;
                  end
               end else if (wr_done && a_q[g] == addr) begin
                  v_q[g] <= 1'b0;
               end
            end
         end
      end
   endgenerate

   assign sc_ok = v_q[id] && (a_q[id] == addr);
endmodule

// File: rtl/amo_unit.sv
module amo_unit import amo_pkg::*; #(
   parameter int NPROC       = 4,
   parameter int AW          = 4,
   parameter int DW          = 16,
   parameter bit TAS_SET_ONE = 1'b0,
   localparam int IW         = $clog2(NPROC),
   localparam int DEPTH      = 1 << AW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPROC-1:0]    req_valid,
   input  logic [3*NPROC-1:0]  req_op,
   input  logic [AW*NPROC-1:0] req_addr,
   input  logic [DW*NPROC-1:0] req_wdata,
   output logic [NPROC-1:0]    req_grant,
   output logic                rsp_valid,
   output logic [IW-1:0]       rsp_id,
   output logic [DW-1:0]       rsp_data
);
   generate
      if (NPROC < 2)        begin : g_bad_nproc $error("NPROC must be at least 2"); end
      if (AW < 1 || AW > 12) begin : g_bad_aw   $error("AW out of range");          end
      if (DW < 2)           begin : g_bad_dw    $error("DW must be at least 2");    end
   endgenerate

   logic [2:0]    op_a   [NPROC];
   logic [AW-1:0] addr_a [NPROC];
   logic [DW-1:0] wd_a   [NPROC];

   generate
      for (genvar g = 0; g < NPROC; g++) begin : g_unpack
         assign op_a[g]   = req_op[3*g +: 3];
         assign addr_a[g] = req_addr[AW*g +: AW];
         assign wd_a[g]   = req_wdata[DW*g +: DW];
      end
   endgenerate

   logic [IW-1:0] gnt_id;
   logic          gnt_any;

   amo_rr_arb #(.N(NPROC)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_valid),
      .grant   (req_grant),
      .gnt_id  (gnt_id),
      .gnt_any (gnt_any)
   );

   logic [2:0]    sel_op;
   logic [AW-1:0] sel_addr;
   logic [DW-1:0] sel_wdata;
   assign sel_op    = op_a[gnt_id];
   assign sel_addr  = addr_a[gnt_id];
   assign sel_wdata = wd_a[gnt_id];

   logic [DW-1:0] mem_q [DEPTH];
   logic [DW-1:0] old_val, new_val, rsp_val;
   logic          do_wr, sc_ok, wr_done;

   assign old_val = mem_q[sel_addr];

   amo_alu #(.DW(DW), .TAS_SET_ONE(TAS_SET_ONE)) u_alu (
      .op      (amo_op_e'(sel_op)),
      .old_val (old_val),
      .wdata   (sel_wdata),
      .sc_ok   (sc_ok),
      .do_wr   (do_wr),
      .new_val (new_val),
      .rsp_val (rsp_val)
   );

   assign wr_done = gnt_any && do_wr;

   amo_resv #(.NPROC(NPROC), .AW(AW)) u_resv (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (gnt_any),
      .id      (gnt_id),
      .op      (sel_op),
      .addr    (sel_addr),
      .wr_done (wr_done),
      .sc_ok   (sc_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_done) begin
         mem_q[sel_addr] <= new_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_id    <= '0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= gnt_any;
         if (gnt_any) begin
            rsp_id   <= gnt_id;
            rsp_data <= rsp_val;
         end
      end
   end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
   parameter int NPROC = 4,
   parameter int DW    = 16,
   localparam int IW   = $clog2(NPROC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPROC-1:0] req_valid,
   input logic [NPROC-1:0] req_grant,
   input logic             rsp_valid,
   input logic [IW-1:0]    rsp_id,
   input logic [DW-1:0]    rsp_data,
   input logic [2:0]       sel_op
);
   assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_grant));

   assert_grant_to_requester_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant & ~req_valid) == '0);

   assert_no_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_valid) |-> (|req_grant));

   assert_rsp_after_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_grant) |=> rsp_valid);

   assert_no_rsp_without_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_grant) |=> !rsp_valid);

   assert_rsp_id_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (($past(req_grant) & (NPROC'(1) << rsp_id)) != '0));

   assert_sc_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(sel_op) == 3'd6) |-> (rsp_data <= DW'(1)));
endmodule

bind amo_unit amo_unit_chk #(.NPROC(NPROC), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_grant (req_grant),
   .rsp_valid (rsp_valid),
   .rsp_id    (rsp_id),
   .rsp_data  (rsp_data),
   .sel_op    (sel_op)
);

// File: tb/test_amo_unit.sv
`timescale 1ns/1ps
module test_amo_unit;
   localparam int NPROC = 4;
   localparam int AW    = 4;
   localparam int DW    = 16;
   localparam int IW    = $clog2(NPROC);

   localparam logic [2:0] LD = 3'd0, ST = 3'd1, SW = 3'd2, TS = 3'd3,
                          FI = 3'd4, LL = 3'd5, SC = 3'd6, RV = 3'd7;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NPROC-1:0]    req_valid = '0;
   logic [3*NPROC-1:0]  req_op = '0;
   logic [AW*NPROC-1:0] req_addr = '0;
   logic [DW*NPROC-1:0] req_wdata = '0;
   logic [NPROC-1:0]    req_grant;
   logic                rsp_valid;
   logic [IW-1:0]       rsp_id;
   logic [DW-1:0]       rsp_data;

   int nvec = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   amo_unit #(.NPROC(NPROC), .AW(AW), .DW(DW)) i_amo_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
      .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge where the response is seen
   task automatic do_op(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd);
      req_op[3*p +: 3]     = op;
      req_addr[AW*p +: AW] = a;
      req_wdata[DW*p +: DW] = wd;
      req_valid[p] = 1'b1;
      #1;
      chk("R9 grant", 32'(req_grant), 32'(1 << p));
      @(posedge clk);
      #1 req_valid[p] = 1'b0;
      @(negedge clk);
      chk("R10 rsp_valid", 32'(rsp_valid), 32'd1);
      chk("R10 rsp_id", 32'(rsp_id), 32'(p));
      rd = rsp_data;
   endtask

   task automatic t_reset_rr();
      int prev = -1;
      logic [NPROC-1:0] g;
      @(negedge clk);
      chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      for (int p = 0; p < NPROC; p++) begin
         req_op[3*p +: 3] = LD;
         req_addr[AW*p +: AW] = AW'(p + 1);
      end
      req_valid = '1;
      for (int c = 0; c < NPROC; c++) begin
         int id = -1;
         #1;
         g = req_grant;
         for (int i = 0; i < NPROC; i++) if (g[i]) id = i;
         if (c == 0) chk("R1 first grant", 32'(id), 32'd0);
         else        chk("R9 rotation", 32'(id), 32'((prev + 1) % NPROC));
         if (c > 0) begin
            chk("R10 rsp_id echo", 32'(rsp_id), 32'(prev));
            chk("R1 memory zero", 32'(rsp_data), 32'd0);
         end
         prev = id;
         @(posedge clk);
         #1 req_valid = req_valid & ~g;
         @(negedge clk);
      end
      chk("R10 last rsp_id", 32'(rsp_id), 32'(prev));
      chk("R10 last rsp_valid", 32'(rsp_valid), 32'd1);
      @(negedge clk);
      chk("R10 idle no rsp", 32'(rsp_valid), 32'd0);
   endtask

   task automatic t_load_store();
      logic [DW-1:0] r;
      do_op(1, ST, 4'd5, 16'h1234, r); chk("R2 store returns old", 32'(r), 32'h0);
      do_op(2, LD, 4'd5, 16'h0, r);    chk("R2 load", 32'(r), 32'h1234);
      do_op(3, RV, 4'd5, 16'hFFFF, r); chk("R2 code 7 loads", 32'(r), 32'h1234);
      do_op(0, LD, 4'd5, 16'h0, r);    chk("R2 code 7 no write", 32'(r), 32'h1234);
   endtask

   task automatic t_swap();
      logic [DW-1:0] r;
      do_op(0, SW, 4'd2, 16'd1, r); chk("R3 swap free lock", 32'(r), 32'd0);
      do_op(1, SW, 4'd2, 16'd1, r); chk("R3 swap held lock", 32'(r), 32'd1);
      do_op(0, SW, 4'd2, 16'h00C3, r); chk("R3 swap old", 32'(r), 32'd1);
      do_op(2, LD, 4'd2, 16'd0, r); chk("R3 swap wrote", 32'(r), 32'h00C3);
   endtask

   task automatic t_tas();
      logic [DW-1:0] r;
      do_op(0, TS, 4'd4, 16'h00AA, r); chk("R4 tas free", 32'(r), 32'h0);
      do_op(1, TS, 4'd4, 16'h00BB, r); chk("R4 tas held", 32'(r), 32'hAA);
      do_op(2, LD, 4'd4, 16'h0, r);    chk("R4 tas unchanged", 32'(r), 32'hAA);
   endtask

   task automatic t_finc();
      logic [DW-1:0] r;
      do_op(3, ST, 4'd6, 16'hFFFE, r);
      do_op(0, FI, 4'd6, 16'h0, r); chk("R5 finc old", 32'(r), 32'hFFFE);
      do_op(1, FI, 4'd6, 16'h0, r); chk("R5 finc next", 32'(r), 32'hFFFF);
      do_op(2, LD, 4'd6, 16'h0, r); chk("R5 finc wraps", 32'(r), 32'h0);
   endtask

   task automatic t_llsc();
      logic [DW-1:0] r;
      do_op(1, ST, 4'd7, 16'd9, r);
      do_op(2, LL, 4'd7, 16'd0, r);    chk("R6 ll value", 32'(r), 32'd9);
      do_op(2, SC, 4'd7, 16'h55, r);   chk("R6 sc success", 32'(r), 32'd1);
      do_op(0, LD, 4'd7, 16'd0, r);    chk("R6 sc wrote", 32'(r), 32'h55);
      do_op(2, SC, 4'd7, 16'h66, r);   chk("R8 sc after success fails", 32'(r), 32'd0);
      do_op(0, LD, 4'd7, 16'd0, r);    chk("R8 no write", 32'(r), 32'h55);
   endtask

   task automatic t_sc_conflict();
      logic [DW-1:0] r;
      do_op(0, LL, 4'd8, 16'd0, r);
      do_op(1, ST, 4'd8, 16'd3, r);
      do_op(0, SC, 4'd8, 16'h77, r);   chk("R7 sc after store fails", 32'(r), 32'd0);
      do_op(2, LD, 4'd8, 16'd0, r);    chk("R7 memory kept", 32'(r), 32'd3);
      do_op(0, LL, 4'd8, 16'd0, r);
      do_op(3, FI, 4'd8, 16'd0, r);
      do_op(0, SC, 4'd8, 16'h77, r);   chk("R7 sc after finc fails", 32'(r), 32'd0);
      do_op(1, LL, 4'd11, 16'd0, r);
      do_op(2, ST, 4'd12, 16'd1, r);
      do_op(1, SC, 4'd11, 16'h42, r);  chk("R7 other address keeps resv", 32'(r), 32'd1);
   endtask

   task automatic t_sc_noresv();
      logic [DW-1:0] r;
      do_op(3, SC, 4'd9, 16'h11, r);   chk("R8 sc no resv", 32'(r), 32'd0);
      do_op(0, LD, 4'd9, 16'd0, r);    chk("R8 no resv no write", 32'(r), 32'd0);
      do_op(3, LL, 4'd9, 16'd0, r);
      do_op(3, SC, 4'd10, 16'h22, r);  chk("R8 sc wrong addr", 32'(r), 32'd0);
      do_op(0, LD, 4'd10, 16'd0, r);   chk("R8 wrong addr no write", 32'(r), 32'd0);
      do_op(3, SC, 4'd9, 16'h33, r);   chk("R8 resv cleared", 32'(r), 32'd0);
      do_op(0, LD, 4'd9, 16'd0, r);    chk("R8 cleared no write", 32'(r), 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset_rr();
      t_load_store();
      t_swap();
      t_tas();
      t_finc();
      t_llsc();
      t_sc_conflict();
      t_sc_noresv();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nvec++;
         nfail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end
endmodule